// File: doc/BRIEF.md
# Configuration Frame Loader

The loader sits behind a configuration packet decoder. It takes one payload beat per cycle, each beat carrying an opcode, a target register code, a 32-bit word and an end-of-packet flag. A separate flag marks a packet header that carries no payload at all. From these beats the block keeps track of the few configuration registers that steer frame loading. It then turns payload sent to the frame-data register into a stream of frame word writes. Each write carries a frame address, a word index and the data word.

A write-configuration command arms a start flag. The first beat of the next frame-data packet then takes its frame address from the address register. After that, the address steps on by itself after every complete frame. When a step crosses into another row, another half or another block type, the two frames of filler that follow in the payload are dropped. Loading stops once the device has no next frame. A device identifier that does not match a fixed parameter marks the stream as bad. A frame left unfinished at the end of a packet raises a sticky error.

The next-address function is a parameterised counter. Its digits, from least to most significant, are minor frame, column, row, half and block type.

Top module: `cfl_frame_loader`

## Requirements
- R1: After reset, fw_valid, fw_frame_done, stream_bad and partial_err are all 0.
- R2: Only beats with pkt_op = 2'b10 (write) and pkt_nodata = 0 have any effect on registers or outputs. Read (01), no-op (00) and reserved (11) beats are ignored, and so are payload-free beats.
- R3: A write to the control register (code 5) stores the payload ANDed with the mask register (code 4). Only bit 21 of the stored value matters; it is the restart-inhibit bit.
- R4: Writing 0x00000001 to the command register (code 3) arms the start flag. The first beat of the next frame-data packet (code 2) takes its frame address from the address register (code 1) and clears the flag. A frame-data packet that starts with the flag clear continues from the current frame address at word index 0.
- R5: A write to the address register re-arms the start flag when the command register holds 0x00000001 and the stored inhibit bit is 0. Otherwise the write only changes the address.
- R6: A write to the identifier register (code 6) with a value other than EXPECTED_ID sets stream_bad, which stays set until reset.
- R7: Each accepted frame-data word appears one cycle later on fw_valid, with fw_addr, fw_idx and fw_data. The index runs from 0 to WORDS_PER_FRAME-1. fw_frame_done is high together with the word at the last index, and the frame address then moves to the next frame.
- R8: When the next frame lies in a different row, half or block type, the following PAD_FRAMES*WORDS_PER_FRAME payload words of the same packet are dropped without output.
- R9: After the last frame of the device is completed, the remaining words of that packet produce no output.
- R10: If a frame-data packet ends while a frame is incomplete, and the loader is neither padding nor stopped, partial_err is set and stays set until reset.
- R11: The frame address is laid out as minor [7:0], column [15:8], row [20:16], half [21] and block type [24:22]. Minor wraps at MINOR_N, column at COL_N, row at ROW_N, half at 2 and block type at BT_N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pkt_valid | input | 1 | A packet beat is present |
| pkt_op | input | 2 | Opcode of the packet |
| pkt_reg | input | 5 | Target register code |
| pkt_data | input | 32 | Payload word |
| pkt_last | input | 1 | Final beat of the packet |
| pkt_nodata | input | 1 | The beat is a header with no payload |
| fw_valid | output | 1 | A frame word write is present |
| fw_addr | output | 32 | Frame address of the write |
| fw_idx | output | 7 | Word index within the frame |
| fw_data | output | 32 | Frame word |
| fw_frame_done | output | 1 | The write completes its frame |
| stream_bad | output | 1 | A device identifier mismatch was seen |
| partial_err | output | 1 | A packet ended inside a frame |

## Verification
Two things can fall on the same beat: the completion of a frame and the end of its packet. On that beat the frame strobe must fire while the partial-frame error stays clear, and the boundary padding, or the stop, must be set up for a packet that never comes. Directed packets whose length is an exact multiple of a frame provoke this. So do packets that run one filler block past a row edge, or stop right at the last frame. Random packets of random length then make the end land both on and off frame edges. Every beat is judged against a bench model that works out the address order from a linear frame number.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_RSVD  = 2'b11
  } cfl_op_e;

  localparam logic [4:0] RA_ADDR  = 5'd1;
  localparam logic [4:0] RA_FDATA = 5'd2;
  localparam logic [4:0] RA_CMD   = 5'd3;
  localparam logic [4:0] RA_MASK  = 5'd4;
  localparam logic [4:0] RA_CTRL  = 5'd5;
  localparam logic [4:0] RA_DEVID = 5'd6;

  localparam logic [31:0] CMD_LOAD_CFG = 32'h0000_0001;
  localparam int INHIBIT_BIT = 21;

  localparam int MINOR_W   = 8;
  localparam int COL_W     = 8;
  localparam int ROW_W     = 5;
  localparam int BT_W      = 3;
  localparam int MINOR_LSB = 0;
  localparam int COL_LSB   = MINOR_LSB + MINOR_W;
  localparam int ROW_LSB   = COL_LSB + COL_W;
  localparam int HALF_BIT  = ROW_LSB + ROW_W;
  localparam int BT_LSB    = HALF_BIT + 1;
endpackage

// File: rtl/cfl_next_addr.sv
module cfl_next_addr
  import cfl_pkg::*;
#(
  parameter int MINOR_N = 4,
  parameter int COL_N   = 3,
  parameter int ROW_N   = 2,
  parameter int BT_N    = 2
) (
  input  logic [31:0] cur,
  output logic [31:0] nxt,
  output logic        nxt_ok,
  output logic        crosses
);
  localparam logic [MINOR_W-1:0] MINOR_LAST = MINOR_W'(MINOR_N - 1);
  localparam logic [COL_W-1:0]   COL_LAST   = COL_W'(COL_N - 1);
  localparam logic [ROW_W-1:0]   ROW_LAST   = ROW_W'(ROW_N - 1);
  localparam logic [BT_W-1:0]    BT_LAST    = BT_W'(BT_N - 1);

  logic [MINOR_W-1:0] mi, nmi;
  logic [COL_W-1:0]   col, ncol;
  logic [ROW_W-1:0]   row, nrow;
  logic               half, nhalf;
  logic [BT_W-1:0]    bt, nbt;

  always_comb begin
    mi    = cur[MINOR_LSB +: MINOR_W];
    col   = cur[COL_LSB +: COL_W];
    row   = cur[ROW_LSB +: ROW_W];
    half  = cur[HALF_BIT];
    bt    = cur[BT_LSB +: BT_W];
    nmi   = mi + 1'b1;
    ncol  = col;
    nrow  = row;
    nhalf = half;
    nbt   = bt;
    nxt_ok = 1'b1;
    if (mi == MINOR_LAST) begin
      nmi = '0;
      if (col != COL_LAST) ncol = col + 1'b1;
      else begin
        ncol = '0;
        if (row != ROW_LAST) nrow = row + 1'b1;
        else begin
          nrow = '0;
          if (!half) nhalf = 1'b1;
          else begin
            nhalf = 1'b0;
            if (bt != BT_LAST) nbt = bt + 1'b1;
            else nxt_ok = 1'b0;
          end
        end
      end
    end
    nxt = cur;
    nxt[MINOR_LSB +: MINOR_W] = nmi;
    nxt[COL_LSB +: COL_W]     = ncol;
    nxt[ROW_LSB +: ROW_W]     = nrow;
    nxt[HALF_BIT]             = nhalf;
    nxt[BT_LSB +: BT_W]       = nbt;
    crosses = (nbt != bt) || (nhalf != half) || (nrow != row);
  end
endmodule

// File: rtl/cfl_regs.sv
module cfl_regs
  import cfl_pkg::*;
#(
  parameter logic [31:0] EXPECTED_ID = 32'h1357_9BDF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_reg,
  input  logic [31:0] wr_data,
  input  logic        consume,
  output logic [31:0] far_q,
  output logic        armed_q,
  output logic        bad_q
);
  logic        mask_bit_q, mask_bit_n;
  logic        inhibit_q, inhibit_n;
  logic        cmd_load_q, cmd_load_n;
  logic [31:0] far_n;
  logic        armed_n, bad_n;
  logic        upd;

  always_comb begin
    mask_bit_n = mask_bit_q;
    inhibit_n  = inhibit_q;
    cmd_load_n = cmd_load_q;
    far_n      = far_q;
    bad_n      = bad_q;
    armed_n    = armed_q & ~consume;
    if (wr_en) begin
      unique case (wr_reg)
        RA_MASK: mask_bit_n = wr_data[INHIBIT_BIT];
        RA_CTRL: inhibit_n  = wr_data[INHIBIT_BIT] & mask_bit_q;
        RA_CMD: begin
          cmd_load_n = (wr_data == CMD_LOAD_CFG);
          if (wr_data == CMD_LOAD_CFG) armed_n = 1'b1;
        end
        RA_ADDR: begin
          far_n = wr_data;
          if (cmd_load_q && !inhibit_q) armed_n = 1'b1;
        end
        RA_DEVID: if (wr_data != EXPECTED_ID) bad_n = 1'b1;
        default: ;
      endcase
    end
    upd = wr_en | consume;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_bit_q <= 1'b0;
      inhibit_q  <= 1'b0;
      cmd_load_q <= 1'b0;
      far_q      <= '0;
      armed_q    <= 1'b0;
      bad_q      <= 1'b0;
    end else if (upd) begin
      mask_bit_q <= mask_bit_n;
      inhibit_q  <= inhibit_n;
      cmd_load_q <= cmd_load_n;
      far_q      <= far_n;
      armed_q    <= armed_n;
      bad_q      <= bad_n;
    end
  end
endmodule

// File: rtl/cfl_frame_writer.sv
module cfl_frame_writer
  import cfl_pkg::*;
#(
  parameter int WORDS_PER_FRAME = 93,
  parameter int PAD_FRAMES      = 2,
  parameter int MINOR_N         = 4,
  parameter int COL_N           = 3,
  parameter int ROW_N           = 2,
  parameter int BT_N            = 2,
  localparam int IDX_W          = $clog2(WORDS_PER_FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_valid,
  input  logic             beat_last,
  input  logic             fd_en,
  input  logic [31:0]      data,
  input  logic             armed,
  input  logic [31:0]      far,
  output logic             consume,
  output logic             fw_valid,
  output logic [31:0]      fw_addr,
  output logic [IDX_W-1:0] fw_idx,
  output logic [31:0]      fw_data,
  output logic             fw_frame_done,
  output logic             partial_err
);
  localparam int PAD_WORDS = PAD_FRAMES * WORDS_PER_FRAME;
  localparam int PAD_CW    = $clog2(PAD_WORDS + 1);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(WORDS_PER_FRAME - 1);
  localparam logic [PAD_CW-1:0] PAD_LOAD = PAD_CW'(PAD_WORDS);

  logic              in_pkt_q, in_pkt_n;
  logic [31:0]       cur_q, cur_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [PAD_CW-1:0] pad_q, pad_n;
  logic              stop_q, stop_n;
  logic              perr_n;
  logic              v_n, done_n;
  logic [31:0]       addr_n, wdata_n;
  logic [IDX_W-1:0]  oidx_n;

  logic              first;
  logic [31:0]       base;
  logic [IDX_W-1:0]  idx_e;
  logic [PAD_CW-1:0] pad_e;
  logic              stop_e;
  logic [31:0]       nxt;
  logic              nxt_ok, crosses;

  cfl_next_addr #(
    .MINOR_N(MINOR_N), .COL_N(COL_N), .ROW_N(ROW_N), .BT_N(BT_N)
  ) u_next (
    .cur(base), .nxt(nxt), .nxt_ok(nxt_ok), .crosses(crosses)
  );

  always_comb begin
    first  = ~in_pkt_q;
    base   = (first && armed) ? far : cur_q;
    idx_e  = first ? '0 : idx_q;
    pad_e  = first ? '0 : pad_q;
    stop_e = first ? 1'b0 : stop_q;
    in_pkt_n = beat_valid ? ~beat_last : in_pkt_q;
    cur_n   = cur_q;
    idx_n   = idx_q;
    pad_n   = pad_q;
    stop_n  = stop_q;
    perr_n  = partial_err;
    consume = 1'b0;
    v_n     = 1'b0;
    done_n  = 1'b0;
    addr_n  = fw_addr;
    oidx_n  = fw_idx;
    wdata_n = fw_data;
    if (fd_en) begin
      consume = first & armed;
      cur_n   = base;
      idx_n   = idx_e;
      pad_n   = pad_e;
      stop_n  = stop_e;
      if (stop_e) begin
        stop_n = 1'b1;
      end else if (pad_e != '0) begin
        pad_n = pad_e - 1'b1;
      end else begin
        v_n     = 1'b1;
        addr_n  = base;
        oidx_n  = idx_e;
        wdata_n = data;
        if (idx_e == LAST_IDX) begin
          done_n = 1'b1;
          idx_n  = '0;
          if (nxt_ok) begin
            cur_n = nxt;
            pad_n = crosses ? PAD_LOAD : '0;
          end else begin
            stop_n = 1'b1;
          end
        end else begin
          idx_n = idx_e + 1'b1;
        end
      end
      if (beat_last && !stop_e && (pad_e == '0) && (idx_e != LAST_IDX))
        perr_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q      <= 1'b0;
      cur_q         <= '0;
      idx_q         <= '0;
      pad_q         <= '0;
      stop_q        <= 1'b0;
      partial_err   <= 1'b0;
      fw_valid      <= 1'b0;
      fw_frame_done <= 1'b0;
      fw_addr       <= '0;
      fw_idx        <= '0;
      fw_data       <= '0;
    end else begin
      fw_valid      <= v_n;
      fw_frame_done <= done_n;
      if (beat_valid) in_pkt_q <= in_pkt_n;
      if (fd_en) begin
        cur_q       <= cur_n;
        idx_q       <= idx_n;
        pad_q       <= pad_n;
        stop_q      <= stop_n;
        partial_err <= perr_n;
      end
      if (v_n) begin
        fw_addr <= addr_n;
        fw_idx  <= oidx_n;
        fw_data <= wdata_n;
      end
    end
  end
endmodule

// File: rtl/cfl_frame_loader.sv
module cfl_frame_loader
  import cfl_pkg::*;
#(
  parameter int          WORDS_PER_FRAME = 93,
  parameter int          PAD_FRAMES      = 2,
  parameter int          MINOR_N         = 4,
  parameter int          COL_N           = 3,
  parameter int          ROW_N           = 2,
  parameter int          BT_N            = 2,
  parameter logic [31:0] EXPECTED_ID     = 32'h1357_9BDF
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               pkt_valid,
  input  logic [1:0]                         pkt_op,
  input  logic [4:0]                         pkt_reg,
  input  logic [31:0]                        pkt_data,
  input  logic                               pkt_last,
  input  logic                               pkt_nodata,
  output logic                               fw_valid,
  output logic [31:0]                        fw_addr,
  output logic [$clog2(WORDS_PER_FRAME)-1:0] fw_idx,
  output logic [31:0]                        fw_data,
  output logic                               fw_frame_done,
  output logic                               stream_bad,
  output logic                               partial_err
);
  logic [1:0]  rst_sync;
  logic        rst_i;
  logic        wr_en, fd_en, consume, armed;
  logic [31:0] far;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign wr_en = pkt_valid && (pkt_op == OP_WRITE) && !pkt_nodata;
  assign fd_en = wr_en && (pkt_reg == RA_FDATA);

  cfl_regs #(.EXPECTED_ID(EXPECTED_ID)) u_regs (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .wr_reg(pkt_reg),
    .wr_data(pkt_data), .consume(consume), .far_q(far),
    .armed_q(armed), .bad_q(stream_bad)
  );

  cfl_frame_writer #(
    .WORDS_PER_FRAME(WORDS_PER_FRAME), .PAD_FRAMES(PAD_FRAMES),
    .MINOR_N(MINOR_N), .COL_N(COL_N), .ROW_N(ROW_N), .BT_N(BT_N)
  ) u_writer (
    .clk(clk), .rst_n(rst_i), .beat_valid(pkt_valid), .beat_last(pkt_last),
    .fd_en(fd_en), .data(pkt_data), .armed(armed), .far(far),
    .consume(consume), .fw_valid(fw_valid), .fw_addr(fw_addr),
    .fw_idx(fw_idx), .fw_data(fw_data), .fw_frame_done(fw_frame_done),
    .partial_err(partial_err)
  );
endmodule

// File: rtl/cfl_checker.sv
module cfl_checker #(
  parameter int WORDS_PER_FRAME = 93,
  localparam int IDX_W = $clog2(WORDS_PER_FRAME)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_valid,
  input logic [1:0]       pkt_op,
  input logic             pkt_nodata,
  input logic             fw_valid,
  input logic [IDX_W-1:0] fw_idx,
  input logic             fw_frame_done,
  input logic             stream_bad,
  input logic             partial_err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS_PER_FRAME - 1);

  AST_NONWRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_op != 2'b10) |=> !fw_valid); // R2
  AST_NODATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_nodata) |=> !fw_valid); // R2
  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stream_bad |=> stream_bad); // R6
  AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    fw_frame_done |-> (fw_valid && fw_idx == LAST_IDX)); // R7
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fw_valid |-> (fw_idx <= LAST_IDX)); // R7
  AST_PARTIAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    partial_err |=> partial_err); // R10
endmodule

bind cfl_frame_loader cfl_checker #(.WORDS_PER_FRAME(WORDS_PER_FRAME)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_op(pkt_op),
  .pkt_nodata(pkt_nodata), .fw_valid(fw_valid), .fw_idx(fw_idx),
  .fw_frame_done(fw_frame_done), .stream_bad(stream_bad),
  .partial_err(partial_err)
);

// File: tb/sim_cfl_frame_loader.sv
`timescale 1ns/1ps
module sim_cfl_frame_loader;
  localparam int W      = 93;
  localparam int PADF   = 2;
  localparam int MN     = 4;
  localparam int CN     = 3;
  localparam int RN     = 2;
  localparam int BN     = 2;
  localparam int TOTAL  = BN * 2 * RN * CN * MN;
  localparam int ROWGRP = CN * MN;
  localparam logic [31:0] ID = 32'h1357_9BDF;

  logic clk = 1'b0;
  logic rst_n;
  logic pkt_valid, pkt_last, pkt_nodata;
  logic [1:0] pkt_op;
  logic [4:0] pkt_reg;
  logic [31:0] pkt_data;
  logic fw_valid, fw_frame_done, stream_bad, partial_err;
  logic [31:0] fw_addr, fw_data;
  logic [6:0] fw_idx;

  always #2.5 clk = ~clk;

  cfl_frame_loader u0 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_op(pkt_op),
    .pkt_reg(pkt_reg), .pkt_data(pkt_data), .pkt_last(pkt_last),
    .pkt_nodata(pkt_nodata), .fw_valid(fw_valid), .fw_addr(fw_addr),
    .fw_idx(fw_idx), .fw_data(fw_data), .fw_frame_done(fw_frame_done),
    .stream_bad(stream_bad), .partial_err(partial_err)
  );

  int n_chk = 0, n_fail = 0;
  string tag = "R7";

  // bench model state
  logic        m_mask, m_inh, m_cmd, m_armed, m_bad, m_inpkt, m_stop, m_perr;
  logic [31:0] m_far, m_cur;
  int          m_idx, m_pad;

  function automatic int fa2lin(logic [31:0] fa);
    int mi = fa[7:0], co = fa[15:8], ro = fa[20:16], ha = fa[21], b = fa[24:22];
    return (((b * 2 + ha) * RN + ro) * CN + co) * MN + mi;
  endfunction

  function automatic logic [31:0] lin2fa(int lin);
    int t = lin;
    logic [31:0] fa = '0;
    fa[7:0]   = 8'(t % MN); t = t / MN;
    fa[15:8]  = 8'(t % CN); t = t / CN;
    fa[20:16] = 5'(t % RN); t = t / RN;
    fa[21]    = 1'(t % 2);  t = t / 2;
    fa[24:22] = 3'(t);
    return fa;
  endfunction

  task automatic chk(string name, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, name, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mask = 0; m_inh = 0; m_cmd = 0; m_armed = 0; m_bad = 0; m_inpkt = 0;
    m_stop = 0; m_perr = 0; m_far = 0; m_cur = 0; m_idx = 0; m_pad = 0;
  endtask

  // drive one beat at a negedge, check the outputs at the next negedge
  task automatic beat(logic [1:0] op, logic [4:0] rg, logic [31:0] d,
                      logic last, logic nod);
    logic first, wr, e_v, e_done;
    logic [31:0] e_addr, base;
    int e_idx, idx, pad, lin;
    logic stop, stop0;
    int pad0, idx0;
    pkt_valid = 1; pkt_op = op; pkt_reg = rg; pkt_data = d;
    pkt_last = last; pkt_nodata = nod;
    first = !m_inpkt;
    m_inpkt = !last;
    wr = (op == 2'b10) && !nod;
    e_v = 0; e_done = 0; e_addr = 0; e_idx = 0;
    if (wr) begin
      case (rg)
        5'd4: m_mask = d[21];
        5'd5: m_inh = d[21] & m_mask;
        5'd3: begin m_cmd = (d == 32'h1); if (d == 32'h1) m_armed = 1; end
        5'd1: begin m_far = d; if (m_cmd && !m_inh) m_armed = 1; end
        5'd6: if (d != ID) m_bad = 1;
        5'd2: begin
          if (first && m_armed) begin base = m_far; m_armed = 0; end
          else base = m_cur;
          idx  = first ? 0 : m_idx;
          pad  = first ? 0 : m_pad;
          stop = first ? 1'b0 : m_stop;
          stop0 = stop; pad0 = pad; idx0 = idx;
          if (stop) ;
          else if (pad > 0) pad--;
          else begin
            e_v = 1; e_addr = base; e_idx = idx;
            if (idx == W - 1) begin
              e_done = 1; idx = 0;
              lin = fa2lin(base);
              if (lin + 1 >= TOTAL) stop = 1;
              else begin
                pad = ((lin + 1) / ROWGRP != lin / ROWGRP) ? PADF * W : 0;
                base = lin2fa(lin + 1);
              end
            end else idx++;
          end
          if (last && !stop0 && pad0 == 0 && idx0 != W - 1) m_perr = 1;
          m_cur = base; m_idx = idx; m_pad = pad; m_stop = stop;
        end
        default: ;
      endcase
    end
    @(negedge clk);
    chk("fw_valid", 32'(fw_valid), 32'(e_v));
    if (e_v) begin
      chk("fw_addr", fw_addr, e_addr);
      chk("fw_idx", 32'(fw_idx), 32'(e_idx));
      chk("fw_data", fw_data, d);
      chk("fw_frame_done", 32'(fw_frame_done), 32'(e_done));
    end else chk("fw_frame_done", 32'(fw_frame_done), 0);
    chk("stream_bad", 32'(stream_bad), 32'(m_bad));
    chk("partial_err", 32'(partial_err), 32'(m_perr));
    pkt_valid = 0;
  endtask

  task automatic wr1(logic [4:0] rg, logic [31:0] d);
    beat(2'b10, rg, d, 1'b1, 1'b0);
  endtask

  task automatic fdata(int n);
    for (int i = 0; i < n; i++) beat(2'b10, 5'd2, $urandom, i == n - 1, 1'b0);
  endtask

  initial begin
    #950000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    rst_n = 0; pkt_valid = 0; pkt_op = 0; pkt_reg = 0; pkt_data = 0;
    pkt_last = 0; pkt_nodata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("fw_valid", 32'(fw_valid), 0);
    chk("fw_frame_done", 32'(fw_frame_done), 0);
    chk("stream_bad", 32'(stream_bad), 0);
    chk("partial_err", 32'(partial_err), 0);

    // R2: ignored opcodes and payload-free writes
    tag = "R2";
    beat(2'b01, 5'd1, lin2fa(7), 1, 0);
    beat(2'b00, 5'd3, 32'h1, 1, 0);
    beat(2'b11, 5'd6, 32'hDEAD, 1, 0);
    beat(2'b10, 5'd3, 32'h1, 1, 1);
    beat(2'b01, 5'd2, 32'h55, 1, 0);
    fdata(W);                       // unarmed: starts at frame 0

    // R4: command arms, packet starts at the address register
    tag = "R4";
    wr1(5'd1, lin2fa(5));
    wr1(5'd3, 32'h1);
    tag = "R7";
    fdata(2 * W);                   // frame end coincides with packet end

    // R8: row boundary padding
    tag = "R8";
    wr1(5'd1, lin2fa(ROWGRP - 1));
    wr1(5'd3, 32'h1);
    fdata(W + PADF * W + W);

    // R11: half / block-type boundary also pads
    tag = "R11";
    wr1(5'd1, lin2fa(2 * RN * ROWGRP - 1));
    wr1(5'd3, 32'h1);
    fdata(W + PADF * W + 3);

    // R9: stop after last frame
    tag = "R9";
    wr1(5'd3, 32'h1);
    wr1(5'd1, lin2fa(TOTAL - 1));
    fdata(2 * W + 5);

    // R5: inhibit bit blocks re-arm
    tag = "R5";
    wr1(5'd4, 32'h0020_0000);
    wr1(5'd5, 32'h0020_0000);
    wr1(5'd3, 32'h1);
    fdata(W);
    wr1(5'd1, lin2fa(20));
    fdata(W);                       // continues, not frame 20

    // R3: mask clears the inhibit bit on write
    tag = "R3";
    wr1(5'd4, 32'h0);
    wr1(5'd5, 32'hFFFF_FFFF);
    wr1(5'd1, lin2fa(30));
    fdata(W);                       // re-armed: frame 30

    // R6: identifier
    tag = "R6";
    wr1(5'd6, ID);
    wr1(5'd6, ID ^ 32'h1);
    wr1(5'd6, ID);

    // R10: partial frame
    tag = "R10";
    wr1(5'd3, 32'h1);
    fdata(10);

    // random traffic
    tag = "R7";
    for (int p = 0; p < 500; p++) begin
      int k = $urandom % 10;
      case (k)
        0: wr1(5'd1, lin2fa($urandom % TOTAL));
        1: wr1(5'd3, ($urandom % 2) ? 32'h1 : 32'($urandom % 4));
        2: wr1(5'd4, ($urandom % 2) ? 32'h0020_0000 : 32'h0);
        3: wr1(5'd5, ($urandom % 2) ? 32'hFFFF_FFFF : 32'h0);
        4: beat(2'($urandom % 4), 5'($urandom % 8), $urandom, 1, 1'($urandom % 2));
        5: wr1(5'd6, ($urandom % 8 == 0) ? $urandom : ID);
        default: fdata(1 + $urandom % 300);
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule